// File: doc/BRIEF.md
# Power-Management Timer and Event Controller

This block keeps a free-running power-management count that advances on an external tick-enable strobe. The strobe is meant to arrive at 3.579545 MHz. The block also holds the status, enable and control words that decide the level of a system control interrupt (SCI). A single 16-bit register port serves all reads and writes. A 32-bit read returns the count. A separate byte-write port accepts power-management commands from firmware. Three strobe inputs carry the external events: a power-button press, an alarm event (a stub for a real-time clock) and a global event. Two one-cycle request pulses leave the block: one asks for a system-management interrupt and one asks for soft power-off.

Two small state machines carry the sequencing.

The overflow tracker has two states, `OVF_ARMED` and `OVF_LATCHED`. Its "flip" transition moves it from ARMED to LATCHED on any tick that changes the counter's top bit. Its "clear" transition moves it from LATCHED back to ARMED when a write-one-to-clear to status bit 0 arrives in a cycle with no flip. A flip in that same cycle keeps it LATCHED.

The interrupt-mode machine has two states, `SCI_OFF` and `SCI_ON`. It takes these transitions:
- "cmd-on" to `SCI_ON` on command byte 0xF1.
- "cmd-off" to `SCI_OFF` on command byte 0xF0.
- "ctl-set" to `SCI_ON` on a control write with bit 0 high.
- "ctl-clear" to `SCI_OFF` on a control write with bit 0 low.

A command byte of 0xF1 or 0xF0 takes precedence over a control write in the same cycle.

The mode decides what a button press does. In `SCI_OFF` a press requests power-off directly. In `SCI_ON` it latches button status, provided button events are enabled.

Top module: `pm_event_ctl`

## Requirements
- R1: The count is CNT_W bits wide (default 24). It increments by one, modulo 2^CNT_W, on every clock with `tick_en` high, and holds otherwise. Reading offset 0x08 returns the count zero-extended to 32 bits. A write to 0x08 has no effect.
- R2: Status bit 0 (timer overflow) becomes 1 after any tick that changes the count's most significant bit. That is every crossing of a multiple of 2^(CNT_W-1), which is 0x800000 by default. The bit stays 1 until it is cleared.
- R3: The status word is at offset 0x00 and uses bit 10 (alarm), bit 8 (button), bit 5 (global) and bit 0 (timer). Writing 1 to one of these bits clears it and writing 0 leaves it unchanged. An event in the same cycle as a clear wins. All other bits read 0.
- R4: The enable word at offset 0x02 stores only bits 10, 8, 5 and 0. All other bits read 0.
- R5: `sci_out` is high exactly when some bit among 10, 8, 5 and 0 is 1 in both the status and the enable word. It follows the registers in the same cycle they change.
- R6: The control word at offset 0x04 stores every written bit except bit 13, which always reads 0. Bit 0 is the interrupt-mode flag.
- R7: A control write with bit 13 = 1 and bits 12:10 = 000 produces a one-cycle `softoff_req` in the following cycle. Any other sleep type produces none.
- R8: A command write of 0xF1 sets control bit 0 and a write of 0xF0 clears it. Any other command byte leaves it unchanged.
- R9: Every command write with `smi_cfg_en` high produces a one-cycle `smi_req` in the following cycle. With `smi_cfg_en` low there is no pulse.
- R10: A `pwr_btn` strobe while control bit 0 is 0 produces a one-cycle `softoff_req` in the next cycle. While control bit 0 is 1 and enable bit 8 is 1, the strobe sets status bit 8 instead. While control bit 0 is 1 and enable bit 8 is 0, it has no effect.
- R11: `rtc_evt` sets status bit 10 and `gbl_evt` sets status bit 5, whatever the enables hold.
- R12: With `rst_n` low at a clock edge, the count, status, enable, control and both request outputs go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Count-advance strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| apm_we | input | 1 | Command byte write strobe |
| apm_cmd | input | 8 | Command byte |
| smi_cfg_en | input | 1 | Allows command writes to request an SMI |
| pwr_btn | input | 1 | Power-button press strobe |
| rtc_evt | input | 1 | Alarm event strobe (stub) |
| gbl_evt | input | 1 | Global event strobe |
| sci_out | output | 1 | Interrupt level |
| smi_req | output | 1 | One-cycle SMI request |
| softoff_req | output | 1 | One-cycle power-off request |

## Verification
The hardest situation to reach is the timer-overflow latch. At the default width it needs millions of ticks, and its re-arming only shows after a second crossing. The bench therefore builds the block with a 10-bit count, which preserves the flip-and-latch logic. It strobes the tick every third cycle and keeps the timer offset selected, so the count is compared on every clock. It then clears the overflow between two crossings and runs through the wrap from all ones to zero. Meanwhile a behavioural model tracks the interrupt mode, so that button presses and command bytes are compared in both modes.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam logic [3:0] OFS_STS = 4'h0;
    localparam logic [3:0] OFS_ENA = 4'h2;
    localparam logic [3:0] OFS_CTL = 4'h4;
    localparam logic [3:0] OFS_TMR = 4'h8;

    localparam int BIT_TMR = 0;
    localparam int BIT_GBL = 5;
    localparam int BIT_BTN = 8;
    localparam int BIT_ALM = 10;

    localparam logic [15:0] EVT_MASK = 16'h0521;

    localparam int CTL_MODE   = 0;
    localparam int CTL_GO     = 13;
    localparam int SLP_TYP_LO = 10;
    localparam int SLP_TYP_W  = 3;

    localparam logic [7:0] CMD_MODE_ON  = 8'hF1;
    localparam logic [7:0] CMD_MODE_OFF = 8'hF0;

    typedef enum logic {
        OVF_ARMED   = 1'b0,
        OVF_LATCHED = 1'b1
    } ovf_state_t;

    typedef enum logic {
        SCI_OFF = 1'b0,
        SCI_ON  = 1'b1
    } sci_mode_t;

endpackage

// File: rtl/pm_tick_counter.sv
module pm_tick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count,
    output logic             msb_flip
);
    localparam int LOW_W = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_en)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        count    = cnt_q;
        msb_flip = tick_en && (&cnt_q[LOW_W-1:0]);
    end

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

    assert_msb_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        msb_flip |=> (count[CNT_W-1] != $past(count[CNT_W-1])));

endmodule

// File: rtl/pm_ovf_tracker.sv
module pm_ovf_tracker
    import pm_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msb_flip,
    input  logic clr_req,
    output logic ovf_sts
);
    ovf_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_ARMED:   if (msb_flip) state_d = OVF_LATCHED;
            OVF_LATCHED: if (clr_req && !msb_flip) state_d = OVF_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= OVF_ARMED;
        else
            state_q <= state_d;
    end

    always_comb begin
        ovf_sts = (state_q == OVF_LATCHED);
    end

    assert_ovf_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        msb_flip |=> ovf_sts);

    assert_ovf_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !msb_flip) |=> !ovf_sts);

endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
    import pm_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_ofs,
    input  logic [15:0] wr_data,
    input  logic        btn_press,
    input  logic        alm_evt,
    input  logic        gbl_evt,
    input  logic        cmd_we,
    input  logic [7:0]  cmd_byte,
    input  logic        smi_cfg_en,
    input  logic        ovf_sts,
    output logic        ovf_clr,
    output logic [15:0] sts_word,
    output logic [15:0] ena_word,
    output logic [15:0] ctl_word,
    output logic        sci_level,
    output logic        smi_req,
    output logic        softoff_req
);
    localparam logic [15:0] CTL_KEEP = ~((16'h1 << CTL_GO) | (16'h1 << CTL_MODE));

    sci_mode_t   mode_q, mode_d;
    logic [15:0] ena_q;
    logic [15:0] ctl_rest_q;
    logic        alm_q, gbl_q, btn_q;
    logic        smi_q, off_q;

    logic wr_sts, wr_ena, wr_ctl, sci_on, sleep_go, btn_set;

    always_comb begin
        wr_sts   = wr_en && (wr_ofs == OFS_STS);
        wr_ena   = wr_en && (wr_ofs == OFS_ENA);
        wr_ctl   = wr_en && (wr_ofs == OFS_CTL);
        sci_on   = (mode_q == SCI_ON);
        sleep_go = wr_ctl && wr_data[CTL_GO] &&
                   (wr_data[SLP_TYP_LO +: SLP_TYP_W] == '0);
        btn_set  = btn_press && sci_on && ena_q[BIT_BTN];
        ovf_clr  = wr_sts && wr_data[BIT_TMR];
    end

    // interrupt-mode machine: command byte wins over a control write
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            SCI_OFF: begin
                if (cmd_we && cmd_byte == CMD_MODE_ON)
                    mode_d = SCI_ON;
                else if (!(cmd_we && cmd_byte == CMD_MODE_OFF) && wr_ctl && wr_data[CTL_MODE])
                    mode_d = SCI_ON;
            end
            SCI_ON: begin
                if (cmd_we && cmd_byte == CMD_MODE_OFF)
                    mode_d = SCI_OFF;
                else if (!(cmd_we && cmd_byte == CMD_MODE_ON) && wr_ctl && !wr_data[CTL_MODE])
                    mode_d = SCI_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= SCI_OFF;
            ena_q      <= '0;
            ctl_rest_q <= '0;
            alm_q      <= 1'b0;
            gbl_q      <= 1'b0;
            btn_q      <= 1'b0;
            smi_q      <= 1'b0;
            off_q      <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (wr_ena)
                ena_q <= wr_data & EVT_MASK;
            if (wr_ctl)
                ctl_rest_q <= wr_data & CTL_KEEP;
            alm_q <= alm_evt || (alm_q && !(wr_sts && wr_data[BIT_ALM]));
            gbl_q <= gbl_evt || (gbl_q && !(wr_sts && wr_data[BIT_GBL]));
            btn_q <= btn_set || (btn_q && !(wr_sts && wr_data[BIT_BTN]));
            smi_q <= cmd_we && smi_cfg_en;
            off_q <= sleep_go || (btn_press && !sci_on);
        end
    end

    always_comb begin
        sts_word          = '0;
        sts_word[BIT_TMR] = ovf_sts;
        sts_word[BIT_GBL] = gbl_q;
        sts_word[BIT_BTN] = btn_q;
        sts_word[BIT_ALM] = alm_q;
        ena_word          = ena_q;
        ctl_word          = ctl_rest_q;
        ctl_word[CTL_MODE] = sci_on;
        sci_level         = |(sts_word & ena_q & EVT_MASK);
        smi_req           = smi_q;
        softoff_req       = off_q;
    end

    assert_cmd_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == CMD_MODE_ON) |=> ctl_word[CTL_MODE]);

    assert_cmd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == CMD_MODE_OFF) |=> !ctl_word[CTL_MODE]);

    assert_smi_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> $past(cmd_we && smi_cfg_en));

    assert_off_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        softoff_req |-> $past(wr_en || btn_press));

    assert_btn_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_press && ctl_word[CTL_MODE] && ena_word[BIT_BTN]) |=> sts_word[BIT_BTN]);

    assert_alm_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt |=> sts_word[BIT_ALM]);

endmodule

// File: rtl/pm_event_ctl.sv
module pm_event_ctl
    import pm_evt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic [3:0]  reg_addr,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        apm_we,
    input  logic [7:0]  apm_cmd,
    input  logic        smi_cfg_en,
    input  logic        pwr_btn,
    input  logic        rtc_evt,
    input  logic        gbl_evt,
    output logic        sci_out,
    output logic        smi_req,
    output logic        softoff_req
);
    localparam int RD_W = 32;

    logic [CNT_W-1:0] count;
    logic             msb_flip, ovf_sts, ovf_clr;
    logic [15:0]      sts_word, ena_word, ctl_word;

    pm_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .count    (count),
        .msb_flip (msb_flip)
    );

    pm_ovf_tracker u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .msb_flip (msb_flip),
        .clr_req  (ovf_clr),
        .ovf_sts  (ovf_sts)
    );

    pm_event_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_we),
        .wr_ofs      (reg_addr),
        .wr_data     (reg_wdata),
        .btn_press   (pwr_btn),
        .alm_evt     (rtc_evt),
        .gbl_evt     (gbl_evt),
        .cmd_we      (apm_we),
        .cmd_byte    (apm_cmd),
        .smi_cfg_en  (smi_cfg_en),
        .ovf_sts     (ovf_sts),
        .ovf_clr     (ovf_clr),
        .sts_word    (sts_word),
        .ena_word    (ena_word),
        .ctl_word    (ctl_word),
        .sci_level   (sci_out),
        .smi_req     (smi_req),
        .softoff_req (softoff_req)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_STS: reg_rdata = RD_W'(sts_word);
            OFS_ENA: reg_rdata = RD_W'(ena_word);
            OFS_CTL: reg_rdata = RD_W'(ctl_word);
            OFS_TMR: reg_rdata = RD_W'(count);
            default: reg_rdata = '0;
        endcase
    end

    assert_sci_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci_out) |-> (!$stable(sts_word) || !$stable(ena_word)));

    assert_ctl_go_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_CTL) |=> (ctl_word[CTL_GO] == 1'b0));

endmodule

// File: tb/sim_pm_event_ctl.sv
`timescale 1ns/1ps
module sim_pm_event_ctl;
    localparam int W    = 10;
    localparam int MOD  = 1 << W;
    localparam int HALF = 1 << (W - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [31:0] reg_rdata;
    logic        apm_we = 1'b0;
    logic [7:0]  apm_cmd = 8'h0;
    logic        smi_cfg_en = 1'b0;
    logic        pwr_btn = 1'b0;
    logic        rtc_evt = 1'b0;
    logic        gbl_evt = 1'b0;
    logic        sci_out, smi_req, softoff_req;

    pm_event_ctl #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .apm_we(apm_we), .apm_cmd(apm_cmd), .smi_cfg_en(smi_cfg_en),
        .pwr_btn(pwr_btn), .rtc_evt(rtc_evt), .gbl_evt(gbl_evt),
        .sci_out(sci_out), .smi_req(smi_req), .softoff_req(softoff_req)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    int cyc_n   = 0;
    logic tick_run = 1'b0;
    logic chk_on   = 1'b0;
    logic done     = 1'b0;

    // behavioural reference state
    int          m_cnt = 0;
    logic [15:0] m_st = 0, m_en = 0, m_ctl = 0;
    logic        m_smi = 0, m_off = 0;

    always @(posedge clk) begin
        cyc_n++;
        #2 tick_en = tick_run && (cyc_n % 3 == 0);
    end

    always @(posedge clk) begin : model
        int nc;
        logic old_mode;
        logic [15:0] set_b, clr_b;
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_en = 0; m_ctl = 0; m_smi = 0; m_off = 0;
        end else begin
            old_mode = m_ctl[0];
            nc = tick_en ? (m_cnt + 1) % MOD : m_cnt;
            set_b = 0;
            if (tick_en && ((m_cnt / HALF) % 2 != (nc / HALF) % 2)) set_b[0] = 1'b1;
            if (rtc_evt) set_b[10] = 1'b1;
            if (gbl_evt) set_b[5] = 1'b1;
            if (pwr_btn && old_mode && m_en[8]) set_b[8] = 1'b1;
            clr_b = (reg_we && reg_addr == 4'h0) ? (reg_wdata & 16'h0521) : 16'h0;
            m_off = (reg_we && reg_addr == 4'h4 && reg_wdata[13] && reg_wdata[12:10] == 3'b000)
                    || (pwr_btn && !old_mode);
            m_smi = apm_we && smi_cfg_en;
            m_st  = (m_st & ~clr_b) | set_b;
            if (reg_we && reg_addr == 4'h2) m_en = reg_wdata & 16'h0521;
            if (reg_we && reg_addr == 4'h4) m_ctl = reg_wdata & 16'hDFFF;
            if (apm_we && apm_cmd == 8'hF1) m_ctl[0] = 1'b1;
            else if (apm_we && apm_cmd == 8'hF0) m_ctl[0] = 1'b0;
            m_cnt = nc;
        end
    end

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        case (a)
            4'h0: return {16'h0, m_st};
            4'h2: return {16'h0, m_en};
            4'h4: return {16'h0, m_ctl};
            4'h8: return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual 0x%08h expected 0x%08h", tag, cyc_n, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            cmp("R5 sci_out", 32'(sci_out), 32'(|(m_st & m_en & 16'h0521)));
            cmp("R9 smi_req", 32'(smi_req), 32'(m_smi));
            cmp("R7/R10 softoff_req", 32'(softoff_req), 32'(m_off));
            case (reg_addr)
                4'h0: cmp("R3 status read", reg_rdata, exp_rd(reg_addr));
                4'h2: cmp("R4 enable read", reg_rdata, exp_rd(reg_addr));
                4'h4: cmp("R6 control read", reg_rdata, exp_rd(reg_addr));
                default: cmp("R1 timer/other read", reg_rdata, exp_rd(reg_addr));
            endcase
        end
    end

    always @(posedge clk) begin
        if (cyc_n > 100000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d (all reqs): actual hung expected finish", cyc_n);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(posedge clk); #2;
            reg_we = 0; apm_we = 0; pwr_btn = 0; rtc_evt = 0; gbl_evt = 0;
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(posedge clk); #2;
        reg_we = 1; reg_addr = a; reg_wdata = d;
        idle(1);
    endtask

    task automatic cmd(logic [7:0] b);
        @(posedge clk); #2;
        apm_we = 1; apm_cmd = b;
        idle(1);
    endtask

    task automatic strobe_btn();  @(posedge clk); #2; pwr_btn = 1; idle(1); endtask
    task automatic strobe_rtc();  @(posedge clk); #2; rtc_evt = 1; idle(1); endtask

    // fixed-value check straight from a requirement
    task automatic expect_rd(logic [3:0] a, logic [31:0] e, string tag);
        @(posedge clk); #2; reg_addr = a;
        @(negedge clk);
        cmp(tag, reg_rdata, e);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        chk_on = 1;
        #2 rst_n = 1;
        // R12: everything zero out of reset
        expect_rd(4'h0, 32'h0, "R12 status after reset");
        expect_rd(4'h4, 32'h0, "R12 control after reset");
        expect_rd(4'h8, 32'h0, "R12 timer after reset");

        // R4: only the four event bits are kept
        wr(4'h2, 16'hFFFF);
        expect_rd(4'h2, 32'h0000_0521, "R4 enable mask");
        wr(4'h2, 16'h0000);

        // R11 / R5: alarm event sets bit 10 independent of enable, then sci follows enable
        strobe_rtc();
        expect_rd(4'h0, 32'h0000_0400, "R11 alarm status");
        wr(4'h2, 16'h0400);
        idle(1);
        cmp("R5 sci high", 32'(sci_out), 32'h1);
        // R3: writing zero leaves it, writing one clears
        wr(4'h0, 16'h0000);
        expect_rd(4'h0, 32'h0000_0400, "R3 zero write keeps");
        wr(4'h0, 16'h0400);
        expect_rd(4'h0, 32'h0, "R3 one write clears");

        // R3: global event and clear in the same cycle, event wins (R11 global)
        @(posedge clk); #2; gbl_evt = 1; reg_we = 1; reg_addr = 4'h0; reg_wdata = 16'h0020;
        idle(1);
        expect_rd(4'h0, 32'h0000_0020, "R3 set beats clear");
        wr(4'h0, 16'hFFFF);

        // R6 / R7: control storage and sleep requests
        wr(4'h4, 16'hFFFF);
        expect_rd(4'h4, 32'h0000_DFFF, "R6 bit13 reads zero");
        wr(4'h4, 16'h2000);
        wr(4'h4, 16'h2400);
        wr(4'h4, 16'h0000);

        // R10: button in legacy mode requests soft-off
        strobe_btn();
        // R8 / R9: command bytes
        smi_cfg_en = 1;
        cmd(8'hF1);
        expect_rd(4'h4, 32'h0000_0001, "R8 cmd on");
        cmd(8'h55);
        expect_rd(4'h4, 32'h0000_0001, "R8 other byte ignored");
        // R10: button with mode on and enable on latches status
        wr(4'h2, 16'h0100);
        strobe_btn();
        expect_rd(4'h0, 32'h0000_0100, "R10 button latched");
        wr(4'h0, 16'h0100);
        // R10: enable off, button has no effect
        wr(4'h2, 16'h0000);
        strobe_btn();
        expect_rd(4'h0, 32'h0, "R10 button ignored");
        smi_cfg_en = 0;
        cmd(8'hF0);
        expect_rd(4'h4, 32'h0, "R8 cmd off");
        strobe_btn();

        // R1 / R2: run the count past both boundaries
        wr(4'h2, 16'h0001);
        wr(4'h8, 16'h1234);           // R1: ignored
        reg_addr = 4'h8;
        tick_run = 1;
        idle(HALF * 3 + 20);
        reg_addr = 4'h0;
        idle(2);
        wr(4'h0, 16'h0001);           // re-arm (R2)
        reg_addr = 4'h8;
        idle(HALF * 3 + 20);          // through the wrap
        reg_addr = 4'h0;
        idle(5);
        tick_run = 0;
        idle(3);

        // R12: reset mid-run clears state
        @(posedge clk); #2; rst_n = 0;
        idle(2);
        #0 rst_n = 1;
        expect_rd(4'h0, 32'h0, "R12 status cleared");
        expect_rd(4'h2, 32'h0, "R12 enable cleared");
        expect_rd(4'h8, 32'h0, "R12 timer cleared");
        idle(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule